// File: doc/BRIEF.md
# Run-Time Sizable Byte FIFO with Fill Trigger

This block is a byte queue whose usable capacity is chosen while the chip runs: 16, 32, 64 or 128 entries, all carved out of one storage array built for the largest setting. A producer pushes bytes and a consumer pops them. The oldest byte is always visible on the read port while the queue holds data. Full and empty flags and a live occupancy count report how much is stored.

A fill trigger tells the consumer that enough bytes have built up to be worth servicing. Its threshold comes from a grid. A 2-bit trigger group picks the row and the programmed capacity picks the column, so each group's threshold grows as the capacity grows. Capacity and group are held in one 8-bit mode register. Writing a new capacity empties the queue so that stale pointers never point past the new boundary.

Sticky overrun and underrun flags record refused pushes and pops.

Top module: `scalable_byte_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, level is 0, trigger is 0, overrun and underrun are 0 and the mode register reads 8'h00.
- R2: The mode register holds the size code in bits [1:0] and the trigger group in bits [5:4]. Bits [7:6] and [3:2] are ignored on write and read back as 0.
- R3: The size code selects the capacity: 0 gives 16, 1 gives 32, 2 gives 64 and 3 gives 128 entries. full is 1 exactly when level equals that capacity, and empty is 1 exactly when level is 0.
- R4: Bytes leave in the order they entered. pop_data shows the oldest stored byte whenever empty is 0, including after the pointers wrap at the programmed capacity.
- R5: A push while full is refused: level and the stored bytes are unchanged, and overrun becomes 1 and stays 1 until the next size change. A push and a pop in the same cycle while full perform only the pop.
- R6: A pop while empty is refused: level stays 0, and underrun becomes 1 and stays 1 until the next size change.
- R7: A push and a pop in the same cycle, while the queue is neither full nor empty, leave level unchanged and keep the byte order.
- R8: The threshold is B << G, where G is the trigger group and B is 1, 4, 8 or 14 for size code 0, 1, 2 or 3. trigger is 1 exactly while level is at or above the threshold.
- R9: A mode write whose size code differs from the stored one empties the queue and clears overrun and underrun by the next cycle. This takes priority over a push or pop in the same cycle. A mode write with the same size code only updates the group and keeps the contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_wdata | input | 8 | Mode register write value |
| cfg_rdata | output | 8 | Mode register contents |
| push | input | 1 | Store push_data this cycle |
| push_data | input | DATA_W | Byte to store |
| pop | input | 1 | Remove the oldest byte this cycle |
| pop_data | output | DATA_W | Oldest stored byte, valid while empty is 0 |
| full | output | 1 | Level equals the programmed capacity |
| empty | output | 1 | Level is zero |
| level | output | CNT_W | Number of stored bytes |
| trigger | output | 1 | Level at or above the selected threshold |
| overrun | output | 1 | Sticky: a push was refused |
| underrun | output | 1 | Sticky: a pop was refused |

## Verification
The checker watches the flag relations on every cycle. It confirms that full and empty are exclusive and that full matches the capacity, that level never exceeds the capacity, and that trigger agrees with the threshold grid. It also confirms that refused pushes and pops leave level alone and raise their sticky flags, that balanced push-pop cycles hold level, and that a size change empties the queue. Byte ordering, wrap-around at each capacity and the contents surviving a refused push involve stored data, so only the bench's scenarios can show them. The same holds for a group-only write keeping the contents and for the exact level at which each of the sixteen grid entries first raises trigger.

// File: rtl/fifo_cfg_pkg.sv
package fifo_cfg_pkg;

   typedef enum logic [1:0] {
      SZ_X1 = 2'd0,
      SZ_X2 = 2'd1,
      SZ_X4 = 2'd2,
      SZ_X8 = 2'd3
   } size_code_e;

   typedef struct packed {
      logic [1:0] group;
      logic [1:0] size;
   } mode_t;

   // Row-zero threshold for each capacity column; other groups shift it left.
   function automatic logic [3:0] trig_base(input logic [1:0] size);
      logic [3:0] b;
      case (size)
         2'd0:    b = 4'd1;
         2'd1:    b = 4'd4;
         2'd2:    b = 4'd8;
         default: b = 4'd14;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/fifo_mode_reg.sv
module fifo_mode_reg
   import fifo_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic [1:0] wr_size,
   input  logic [1:0] wr_group,
   output mode_t      mode,
   output logic       flush
);

   mode_t mode_q;

   // A new capacity invalidates the pointers, so it empties the queue.
   assign flush = cfg_we && (wr_size != mode_q.size);
   assign mode  = mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q.size  <= SZ_X1;
         mode_q.group <= 2'd0;
      end else if (cfg_we) begin
         mode_q.size  <= wr_size;
         mode_q.group <= wr_group;
      end
   end

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
   parameter int MIN_DEPTH = 16,
   localparam int MAX_DEPTH = MIN_DEPTH * 8,
   localparam int PTR_W = $clog2(MAX_DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       size,
   input  logic             push,
   input  logic             pop,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] rd_ptr,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             overrun,
   output logic             underrun
);

   logic [CNT_W-1:0] depth;
   logic [CNT_W-1:0] wrap_mask;
   logic [PTR_W-1:0] wr_nxt;
   logic [PTR_W-1:0] rd_nxt;
   logic [CNT_W-1:0] lvl_nxt;
   logic             do_push;
   logic             do_pop;

   assign depth     = CNT_W'(MIN_DEPTH) << size;
   assign wrap_mask = depth - CNT_W'(1);

   assign full  = (level == depth);
   assign empty = (level == '0);

   // Decisions use the state at the start of the cycle.
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign wr_en   = do_push && !flush;

   // Pointers wrap at the programmed capacity, not the physical one.
   assign wr_nxt = PTR_W'(({1'b0, wr_ptr} + CNT_W'(1)) & wrap_mask);
   assign rd_nxt = PTR_W'(({1'b0, rd_ptr} + CNT_W'(1)) & wrap_mask);

   always_comb begin
      lvl_nxt = level;
      if (do_push) lvl_nxt = lvl_nxt + CNT_W'(1);
      if (do_pop)  lvl_nxt = lvl_nxt - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else if (flush) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overrun  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         level <= lvl_nxt;
         if (push && full)  overrun  <= 1'b1;
         if (pop && empty)  underrun <= 1'b1;
      end
   end

endmodule

// File: rtl/fifo_byte_store.sv
module fifo_byte_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 128,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // Fall-through read: the head entry is visible without a pop.
   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/fifo_trig_lookup.sv
module fifo_trig_lookup
   import fifo_cfg_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int THR_IMPL = 0
) (
   input  logic [1:0]       size,
   input  logic [1:0]       group,
   input  logic [CNT_W-1:0] level,
   output logic [CNT_W-1:0] thr,
   output logic             trigger
);

   generate
      if (THR_IMPL == 0) begin : g_shift
         // Group scales the base value by a power of two.
         assign thr = CNT_W'(trig_base(size)) << group;
      end else begin : g_table
         logic [CNT_W-1:0] tbl;
         always_comb begin
            case ({group, size})
               4'h0:    tbl = CNT_W'(1);
               4'h1:    tbl = CNT_W'(4);
               4'h2:    tbl = CNT_W'(8);
               4'h3:    tbl = CNT_W'(14);
               4'h4:    tbl = CNT_W'(2);
               4'h5:    tbl = CNT_W'(8);
               4'h6:    tbl = CNT_W'(16);
               4'h7:    tbl = CNT_W'(28);
               4'h8:    tbl = CNT_W'(4);
               4'h9:    tbl = CNT_W'(16);
               4'hA:    tbl = CNT_W'(32);
               4'hB:    tbl = CNT_W'(56);
               4'hC:    tbl = CNT_W'(8);
               4'hD:    tbl = CNT_W'(32);
               4'hE:    tbl = CNT_W'(64);
               default: tbl = CNT_W'(112);
            endcase
         end
         assign thr = tbl;
      end
   endgenerate

   assign trigger = (level >= thr);

endmodule

// File: rtl/scalable_byte_fifo.sv
module scalable_byte_fifo
   import fifo_cfg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int MIN_DEPTH = 16,
   parameter int THR_IMPL  = 0,
   localparam int MAX_DEPTH = MIN_DEPTH * 8,
   localparam int PTR_W     = $clog2(MAX_DEPTH),
   localparam int CNT_W     = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic              full,
   output logic              empty,
   output logic [CNT_W-1:0]  level,
   output logic              trigger,
   output logic              overrun,
   output logic              underrun
);

   generate
      if (MIN_DEPTH < 16 || (MIN_DEPTH & (MIN_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("MIN_DEPTH must be a power of two of at least 16");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (THR_IMPL != 0 && THR_IMPL != 1) begin : g_bad_impl
         $error("THR_IMPL must be 0 (shift) or 1 (table)");
      end
   endgenerate

   mode_t            mode;
   logic             flush;
   logic             wr_en;
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] thr;
   logic             unused_cfg_bits;

   assign unused_cfg_bits = ^{cfg_wdata[7:6], cfg_wdata[3:2], thr};

   fifo_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .wr_size  (cfg_wdata[1:0]),
      .wr_group (cfg_wdata[5:4]),
      .mode     (mode),
      .flush    (flush)
   );

   assign cfg_rdata = {2'b00, mode.group, 2'b00, mode.size};

   fifo_ptr_ctrl #(.MIN_DEPTH(MIN_DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .size     (mode.size),
      .push     (push),
      .pop      (pop),
      .wr_en    (wr_en),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .level    (level),
      .full     (full),
      .empty    (empty),
      .overrun  (overrun),
      .underrun (underrun)
   );

   fifo_byte_store #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_ptr),
      .wr_data (push_data),
      .rd_addr (rd_ptr),
      .rd_data (pop_data)
   );

   fifo_trig_lookup #(.CNT_W(CNT_W), .THR_IMPL(THR_IMPL)) u_trig (
      .size    (mode.size),
      .group   (mode.group),
      .level   (level),
      .thr     (thr),
      .trigger (trigger)
   );

endmodule

// File: rtl/scalable_byte_fifo_chk.sv
module scalable_byte_fifo_chk #(
   parameter int MIN_DEPTH = 16,
   localparam int CNT_W = $clog2(MIN_DEPTH * 8) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [7:0]       cfg_wdata,
   input logic [7:0]       cfg_rdata,
   input logic             push,
   input logic             pop,
   input logic             full,
   input logic             empty,
   input logic [CNT_W-1:0] level,
   input logic             trigger,
   input logic             overrun,
   input logic             underrun
);

   logic [CNT_W-1:0] cap;
   logic [CNT_W-1:0] exp_thr;
   logic [3:0]       base;
   logic             size_chg;

   assign cap      = CNT_W'(MIN_DEPTH) << cfg_rdata[1:0];
   assign size_chg = cfg_we && (cfg_wdata[1:0] != cfg_rdata[1:0]);

   always_comb begin
      case (cfg_rdata[1:0])
         2'd0:    base = 4'd1;
         2'd1:    base = 4'd4;
         2'd2:    base = 4'd8;
         default: base = 4'd14;
      endcase
   end
   assign exp_thr = CNT_W'(base) << cfg_rdata[5:4];

   assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));

   assert_full_at_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full == (level == cap));

   assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= cap);

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !cfg_we) |=> ($stable(level) && overrun));

   assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !size_chg) |=> overrun);

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !cfg_we) |=> (empty && underrun));

   assert_balanced_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !full && !empty && !cfg_we) |=> $stable(level));

   assert_trigger_grid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trigger == (level >= exp_thr));

   assert_size_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      size_chg |=> (empty && !overrun && !underrun));

endmodule

bind scalable_byte_fifo scalable_byte_fifo_chk #(.MIN_DEPTH(MIN_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .push      (push),
   .pop       (pop),
   .full      (full),
   .empty     (empty),
   .level     (level),
   .trigger   (trigger),
   .overrun   (overrun),
   .underrun  (underrun)
);

// File: tb/scalable_byte_fifo_test.sv
module scalable_byte_fifo_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int MIN_DEPTH  = 16;
   localparam int CNT_W      = $clog2(MIN_DEPTH * 8) + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [7:0]        cfg_wdata = '0;
   logic [7:0]        cfg_rdata;
   logic              push = 1'b0;
   logic [DATA_W-1:0] push_data = '0;
   logic              pop = 1'b0;
   logic [DATA_W-1:0] pop_data;
   logic              full;
   logic              empty;
   logic [CNT_W-1:0]  level;
   logic              trigger;
   logic              overrun;
   logic              underrun;

   int checks = 0;
   int errors = 0;
   logic [1:0] cur_size = 2'd0;
   logic [7:0] mdl [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   scalable_byte_fifo #(.DATA_W(DATA_W), .MIN_DEPTH(MIN_DEPTH)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .push      (push),
      .push_data (push_data),
      .pop       (pop),
      .pop_data  (pop_data),
      .full      (full),
      .empty     (empty),
      .level     (level),
      .trigger   (trigger),
      .overrun   (overrun),
      .underrun  (underrun)
   );

   function automatic int cap_of(input logic [1:0] s);
      return MIN_DEPTH << s;
   endfunction

   function automatic int thr_of(input logic [1:0] s, input logic [1:0] g);
      int b;
      case (s)
         2'd0:    b = 1;
         2'd1:    b = 4;
         2'd2:    b = 8;
         default: b = 14;
      endcase
      return b << g;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      cfg_we = 1'b1;
      cfg_wdata = v;
      step();
      cfg_we = 1'b0;
      if (v[1:0] != cur_size) mdl.delete();
      cur_size = v[1:0];
   endtask

   task automatic set_mode(input logic [1:0] s, input logic [1:0] g);
      wr_cfg({6'b0, s + 2'd1});
      wr_cfg({2'b00, g, 2'b00, s});
   endtask

   task automatic cycle(input logic p, input logic [7:0] d, input logic q);
      logic was_full;
      logic was_empty;
      was_full = (mdl.size() == cap_of(cur_size));
      was_empty = (mdl.size() == 0);
      push = p;
      push_data = d;
      pop = q;
      step();
      push = 1'b0;
      pop = 1'b0;
      if (q && !was_empty) void'(mdl.pop_front());
      if (p && !was_full) mdl.push_back(d);
   endtask

   task automatic drain_check(input string req);
      while (mdl.size() > 0) begin
         check(req, pop_data, mdl[0]);
         cycle(1'b0, 8'h00, 1'b1);
      end
      check(req, empty, 1);
   endtask

   task automatic t_reset();
      check("R1 empty", empty, 1);
      check("R1 full", full, 0);
      check("R1 level", level, 0);
      check("R1 trigger", trigger, 0);
      check("R1 overrun", overrun, 0);
      check("R1 underrun", underrun, 0);
      check("R1 mode", cfg_rdata, 0);
   endtask

   task automatic t_mode_fields();
      wr_cfg(8'hFF);
      check("R2 all-ones readback", cfg_rdata, 8'h33);
      wr_cfg(8'hDE);
      check("R2 mixed readback", cfg_rdata, 8'h12);
      wr_cfg(8'h00);
      check("R2 zero readback", cfg_rdata, 8'h00);
   endtask

   task automatic t_depth(input logic [1:0] s);
      int cap;
      cap = cap_of(s);
      set_mode(s, 2'd0);
      for (int i = 0; i < cap; i++) begin
         if (i == cap - 1) check("R3 not full below capacity", full, 0);
         cycle(1'b1, 8'((i * 7 + s * 37) & 255), 1'b0);
      end
      check("R3 full at capacity", full, 1);
      check("R3 level at capacity", level, cap);
      check("R5 overrun clear before refusal", overrun, 0);
      cycle(1'b1, 8'hA5, 1'b0);
      check("R5 level kept on refused push", level, cap);
      check("R5 overrun set", overrun, 1);
      drain_check("R4 order");
      check("R3 empty after drain", level, 0);
      check("R5 overrun sticky", overrun, 1);
      cycle(1'b0, 8'h00, 1'b1);
      check("R6 level kept on refused pop", level, 0);
      check("R6 underrun set", underrun, 1);
      check("R6 empty kept", empty, 1);
   endtask

   task automatic t_full_push_pop();
      set_mode(2'd0, 2'd0);
      for (int i = 0; i < 16; i++) cycle(1'b1, 8'(i + 100), 1'b0);
      check("R5 head before full push-pop", pop_data, 100);
      cycle(1'b1, 8'hEE, 1'b1);
      check("R5 full push-pop level", level, 15);
      check("R5 full push-pop overrun", overrun, 1);
      drain_check("R5 contents after full push-pop");
   endtask

   task automatic t_trigger();
      for (int s = 0; s < 4; s++) begin
         for (int g = 0; g < 4; g++) begin
            int thr;
            thr = thr_of(2'(s), 2'(g));
            set_mode(2'(s), 2'(g));
            check("R8 trigger low when empty", trigger, 0);
            for (int k = 1; k <= thr; k++) begin
               cycle(1'b1, 8'(k), 1'b0);
               if (k >= thr - 1)
                  check($sformatf("R8 trigger s%0d g%0d level %0d", s, g, k),
                        trigger, (k >= thr) ? 1 : 0);
            end
         end
      end
   endtask

   task automatic t_simultaneous();
      set_mode(2'd0, 2'd0);
      for (int i = 0; i < 3; i++) cycle(1'b1, 8'(i + 1), 1'b0);
      for (int i = 0; i < 20; i++) begin
         check("R7 head during streaming", pop_data, mdl[0]);
         cycle(1'b1, 8'(i + 50), 1'b1);
         check("R7 level held", level, 3);
      end
      drain_check("R4 order after wrap");
   endtask

   task automatic t_flush();
      set_mode(2'd0, 2'd0);
      for (int i = 0; i < 17; i++) cycle(1'b1, 8'(i + 200), 1'b0);
      cycle(1'b0, 8'h00, 1'b0);
      check("R9 pre overrun", overrun, 1);
      wr_cfg(8'h20);
      check("R9 group-only write keeps level", level, 16);
      check("R9 group-only write keeps overrun", overrun, 1);
      check("R9 group applied", cfg_rdata, 8'h20);
      check("R9 head kept", pop_data, 200);
      cfg_we = 1'b1;
      cfg_wdata = 8'h01;
      push = 1'b1;
      push_data = 8'h77;
      step();
      cfg_we = 1'b0;
      push = 1'b0;
      mdl.delete();
      cur_size = 2'd1;
      check("R9 size change level", level, 0);
      check("R9 size change empty", empty, 1);
      check("R9 size change full", full, 0);
      check("R9 size change overrun", overrun, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_fields();
      for (int s = 0; s < 4; s++) t_depth(2'(s));
      t_full_push_pop();
      t_simultaneous();
      t_trigger();
      t_flush();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule